// File: doc/BRIEF.md
# MDIO Station Management Controller

This block is a bus master for the two-wire PHY management link, driven by two host-visible registers. The control register holds the target PHY address, the PHY register index, a clock-range code, a direction flag and a busy flag. The data register holds 16 bits.

The host loads the data register first when writing to the PHY. It then writes the control register with the busy flag set. The block divides the system clock by an amount set by the clock-range code to make MDC. It sends a complete 64-bit management frame on MDIO, starting with the most significant bit. On a write it drives the data. On a read it releases the line and shifts in the PHY's reply. When the frame is finished, the hardware clears busy.

While busy is set, the host's register writes are dropped. This keeps the frame contents and the outgoing data steady. The host polls busy and, after a read, picks up the returned value from the data register.

Top module: `mdio_master`

## Requirements
- R1: After reset both registers read as zero, MDC is low and MDIO is not driven (`mdio_oe` low).
- R2: Reading the control register (`rd_sel`=0) returns the PHY address in bits 15:11, the register index in bits 10:6, the clock-range code in bits 4:2, the direction flag in bit 1 (1 = write, 0 = read) and busy in bit 0. Bit 5 and bits 31:16 read as zero. Reading the data register (`rd_sel`=1) returns the 16 data bits in bits 15:0.
- R3: While busy is 1, host writes to either register (`wr_sel`=0 control, `wr_sel`=1 data) leave both registers unchanged.
- R4: The MDC period is 42, 62, 16 or 26 system-clock cycles for clock-range codes 000, 001, 010 and 011 respectively. High and low phases are each half the period.
- R5: Any clock-range code with bit 2 set (100 to 111) gives an MDC period of 62 cycles.
- R6: A write frame carries, most significant bit first: 32 ones, start 01, opcode 01, the 5-bit PHY address, the 5-bit register index, turnaround 10, and the 16 data bits.
- R7: A read frame uses opcode 10. The block drives MDIO for the first 46 bits, then keeps `mdio_oe` low for the turnaround and for all 16 data bits. On a write, `mdio_oe` stays high for all 64 bits.
- R8: `mdio_o` changes only on the system-clock edge where MDC falls, or where a transfer starts. Read data is sampled on the edge where MDC rises.
- R9: Each transfer produces exactly 64 MDC cycles. Busy clears no more than one system-clock cycle after the 64th falling edge of MDC, and MDC then stays low.
- R10: After a write completes, the data register still holds the value written. After a read completes, it holds the 16 bits the PHY returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 data |
| wr_data | input | 32 | Host write value |
| rd_sel | input | 1 | Read source: 0 control, 1 data |
| rd_data | output | 32 | Selected register contents |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value when driven |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pin |

## Verification
The hardest condition to reach from the ports is the read handoff. The PHY must take the line at exactly the right bit, and the data register must end up holding the reply, not a shifted or truncated copy. To get there, the bench includes a responder that counts rising MDC edges and drives the turnaround zero and the reply bits on falling edges. Each read uses a reply pattern with distinct high and low halves. A register write is also attempted inside every transfer, so the dropped write is checked while the shifter is still running.

// File: rtl/mdio_master.sv
module mdio_master (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  input  logic        rd_sel,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME_BITS = 64;
  localparam int DRIVE_BITS = 46;
  localparam int RX_FIRST   = 48;
  localparam int CW         = 6;
  localparam logic [CW-1:0] LAST_BIT = CW'(FRAME_BITS - 1);

  logic [4:0]  phy_addr, reg_idx;
  logic [2:0]  crange;
  logic        op_wr, busy;
  logic [15:0] data;
  logic [FRAME_BITS-1:0] frame;
  logic [CW-1:0] bit_idx, cnt, half_m1;

  always_comb
    case (crange)
      3'd0:    half_m1 = CW'(20);
      3'd1:    half_m1 = CW'(30);
      3'd2:    half_m1 = CW'(7);
      3'd3:    half_m1 = CW'(12);
      default: half_m1 = CW'(30);
    endcase

  wire host_ok = wr_en && !busy;
  wire tick    = busy && (cnt == half_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_addr <= '0; reg_idx <= '0; crange <= '0; op_wr <= 1'b0; busy <= 1'b0;
      data <= '0; frame <= '0; bit_idx <= '0; cnt <= '0; mdc <= 1'b0;
    end else begin
      if (host_ok && !wr_sel) begin
        phy_addr <= wr_data[15:11];
        reg_idx  <= wr_data[10:6];
        crange   <= wr_data[4:2];
        op_wr    <= wr_data[1];
        busy     <= wr_data[0];
        if (wr_data[0]) begin
          frame   <= {32'hFFFF_FFFF, 2'b01, wr_data[1] ? 2'b01 : 2'b10,
                      wr_data[15:11], wr_data[10:6], 2'b10,
                      wr_data[1] ? data : 16'hFFFF};
          cnt     <= '0;
          bit_idx <= '0;
          mdc     <= 1'b0;
        end
      end
      if (host_ok && wr_sel) data <= wr_data[15:0];
      if (busy) begin
        if (tick) begin
          cnt <= '0;
          mdc <= ~mdc;
          if (!mdc) begin
            if (!op_wr && bit_idx >= CW'(RX_FIRST)) data <= {data[14:0], mdio_i};
          end else if (bit_idx == LAST_BIT) begin
            busy <= 1'b0;
          end else begin
            bit_idx <= bit_idx + 1'b1;
            frame   <= {frame[FRAME_BITS-2:0], 1'b0};
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign mdio_o  = frame[FRAME_BITS-1];
  assign mdio_oe = busy && (op_wr || bit_idx < CW'(DRIVE_BITS));
  assign rd_data = rd_sel ? {16'h0, data}
                          : {16'h0, phy_addr, reg_idx, 1'b0, crange, op_wr, busy};

  // R9
  idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(bit_idx) == LAST_BIT) && !mdc);

  // R3
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> $stable({phy_addr, reg_idx, crange, op_wr}));

  // R10
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_wr) |=> $stable(data));

  // R4
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt <= half_m1);

  // R8
  mdio_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));
endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic mdc, mdio_o, mdio_oe, mdio_i;

  logic phy_en = 1'b0, phy_bit = 1'b1;
  logic cur_wr = 1'b1;
  logic [15:0] rval = '0;
  logic [63:0] capture = '0;
  int rx_cnt = 0, oe_bad = 0, edge_bad = 0;
  int cyc = 0, last_rise = -1, last_fall = -1;
  int per_min = 0, per_max = 0, hi_min = 0, hi_max = 0;
  logic mdc_prev = 1'b0, o_prev = 1'b0, oe_prev = 1'b0;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  mdio_master i_mdio_master (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #(CLK_PERIOD/2) clk = ~clk;

  // PHY responder: sample on rising MDC, drive on falling MDC
  always @(posedge mdc) begin
    capture = {capture[62:0], mdio_i};
    if (rx_cnt < 46 && !mdio_oe) oe_bad++;
    if (rx_cnt >= 46 && (mdio_oe != cur_wr)) oe_bad++;
    rx_cnt++;
  end

  always @(negedge mdc) begin
    if (!cur_wr) begin
      if (rx_cnt == 47) begin phy_en = 1'b1; phy_bit = 1'b0; end
      else if (rx_cnt >= 48 && rx_cnt < 64) begin phy_en = 1'b1; phy_bit = rval[63-rx_cnt]; end
      else phy_en = 1'b0;
    end else phy_en = 1'b0;
  end

  always @(negedge clk) begin
    cyc++;
    if (mdc && !mdc_prev) begin
      if (last_rise >= 0) begin
        if (per_min == 0 || cyc - last_rise < per_min) per_min = cyc - last_rise;
        if (cyc - last_rise > per_max) per_max = cyc - last_rise;
      end
      last_rise = cyc;
    end
    if (!mdc && mdc_prev) begin
      if (hi_min == 0 || cyc - last_rise < hi_min) hi_min = cyc - last_rise;
      if (cyc - last_rise > hi_max) hi_max = cyc - last_rise;
      last_fall = cyc;
    end
    if (oe_prev && mdio_oe && mdio_o != o_prev && !(mdc_prev && !mdc)) edge_bad++;
    mdc_prev = mdc; o_prev = mdio_o; oe_prev = mdio_oe;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input bit sel, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic host_rd(input bit sel, output logic [31:0] v);
    rd_sel = sel; #1; v = rd_data;
  endtask

  function automatic int divisor(input logic [2:0] c);
    case (c)
      3'd0: return 42;
      3'd1: return 62;
      3'd2: return 16;
      3'd3: return 26;
      default: return 62;
    endcase
  endfunction

  task automatic xfer(input bit w, input logic [4:0] a, input logic [4:0] r,
                      input logic [2:0] c, input logic [15:0] d, input logic [15:0] rv);
    logic [31:0] ctl, v;
    logic [63:0] exp_frame;
    int n, div;
    div = divisor(c);
    cur_wr = w; rval = rv; rx_cnt = 0; phy_en = 1'b0;
    per_min = 0; per_max = 0; hi_min = 0; hi_max = 0; last_rise = -1;
    oe_bad = 0; edge_bad = 0;
    ctl = {16'h0, a, r, 1'b0, c, w, 1'b1};
    host_wr(1'b1, {16'h0, d});
    host_wr(1'b0, ctl);
    host_rd(1'b0, v);
    chk(v == ctl, "R2 control readback", v, ctl);
    host_wr(1'b1, {16'h0, ~d});
    host_wr(1'b0, {16'h0, ~a, ~r, 1'b0, ~c, ~w, 1'b1});
    host_rd(1'b0, v);
    chk(v == ctl, "R3 control kept while busy", v, ctl);
    host_rd(1'b1, v);
    chk(v[15:0] == d, "R3 data kept while busy", v[15:0], d);
    n = 0;
    do begin
      @(negedge clk); #1;
      host_rd(1'b0, v);
      n++;
    end while (v[0] && n < 8000);
    chk(!v[0], "R9 busy clears", v[0], 0);
    chk(cyc - last_fall <= 1, "R9 busy clear latency", cyc - last_fall, 1);
    chk(rx_cnt == 64, "R9 MDC cycle count", rx_cnt, 64);
    repeat (3) @(negedge clk);
    #1;
    chk(!mdc && !mdio_oe, "R9 idle after frame", {mdc, mdio_oe}, 0);
    chk(per_min == div && per_max == div, c[2] ? "R5 reserved code period" : "R4 MDC period",
        per_max, div);
    chk(hi_min == div/2 && hi_max == div/2, "R4 MDC high phase", hi_max, div/2);
    exp_frame = {32'hFFFF_FFFF, 2'b01, w ? 2'b01 : 2'b10, a, r, 2'b10, w ? d : rv};
    chk(capture == exp_frame, w ? "R6 write frame" : "R7 read frame", capture, exp_frame);
    chk(oe_bad == 0, "R7 output enable window", oe_bad, 0);
    chk(edge_bad == 0, "R8 MDIO changes on falling MDC", edge_bad, 0);
    host_rd(1'b1, v);
    chk(v == {16'h0, w ? d : rv}, "R10 data register", v, {16'h0, w ? d : rv});
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    #1;
    host_rd(1'b0, v);
    chk(v == 0, "R1 control reset", v, 0);
    host_rd(1'b1, v);
    chk(v == 0, "R1 data reset", v, 0);
    chk(!mdc && !mdio_oe, "R1 line idle", {mdc, mdio_oe}, 0);
    rst_n = 1'b1;
    for (int c = 0; c < 8; c++)
      xfer(1'b1, 5'(3*c + 1), 5'(31 - 2*c), 3'(c), 16'(16'h9C3A ^ (c * 16'h1111)), 16'h0);
    for (int k = 0; k < 6; k++)
      xfer(1'b0, 5'(k * 7), 5'(k * 5 + 2), 3'(k % 4), 16'h0, 16'(16'hF05A ^ (k * 16'h2461)));
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule